// File: doc/BRIEF.md
# Dual-Pixel Panel Output Formatter

This block is the last stage before a flat-panel connector. It takes one stream of processed RGB pixels at the display clock. A valid strobe qualifies each pixel and a data-enable marks the active video. The block drives the panel's pixel buses. In two-phase mode, consecutive active pixels are paired. The first pixel of each pair goes to an even bus and the second to an odd bus. Both buses change together once per pair, so the panel can sample them at half the display rate. In single-phase mode, every active pixel is sent on the odd bus at full rate, and the even bus is left alone.

A depth mode selects between 8 and 6 bits per channel. In 6-bit mode each channel keeps its six most significant bits, right-aligned on the bus. A set of spare pins then copies part of the odd blue channel. In 8-bit mode those spare pins are driven low. The block also generates the clocks for the panel:

- a full-rate data clock and its inverse;
- a half-rate data clock and its inverse.

It registers the data-enable and the sync signals so that they stay aligned with the odd-bus pixel data.

Top module: `panel_out_fmt`

## Requirements
- R1: While rst_ni is low, all six channel buses, test_o, de_o, hsync_o, vsync_o and dclk_half_o are 0.
- R2: In two-phase mode (dual_phase_i=1), the first accepted pixel (pix_valid_i=1 and pix_de_i=1) after pix_de_i has been low goes to the even bus and the next one to the odd bus. Both buses take their new values at the clock edge that captures the second pixel.
- R3: In two-phase mode, the even and odd buses keep their values while the first pixel of the next pair is captured. They change only when a pair completes.
- R4: In single-phase mode (dual_phase_i=0), each accepted pixel appears on the odd bus one clock after it is presented, and the even bus keeps its last value.
- R5: In 8-bit mode (wide_i=1), every channel output carries all 8 bits of its channel unchanged.
- R6: In 6-bit mode (wide_i=0), bits [5:0] of every channel output carry bits [7:2] of the channel, and bits [7:6] are 0.
- R7: test_o is 0 in 8-bit mode. In 6-bit mode it equals bits [5:2] of odd_b_o, which is bits [7:4] of the stored odd blue value.
- R8: dclk_full_o follows clk_i, and dclk_full_n_o is its complement.
- R9: dclk_half_n_o is the complement of dclk_half_o. dclk_half_o toggles on every clock edge while pix_de_i is low or the mode is single-phase. In two-phase mode it is 1 after a pair completes and 0 after the first pixel of a pair is captured.
- R10: de_o, hsync_o and vsync_o equal pix_de_i, hsync_i and vsync_i delayed by one clock, which is the odd-bus pixel latency.
- R11: A cycle with pix_valid_i=0 or pix_de_i=0 changes neither pixel bus. In two-phase mode, a cycle with pix_valid_i=0 and pix_de_i=1 does not advance the pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Display clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dual_phase_i | input | 1 | 1 = two-phase paired output, 0 = single-phase on odd bus |
| wide_i | input | 1 | 1 = 8-bit channels, 0 = 6-bit channels |
| pix_valid_i | input | 1 | Pixel present this cycle |
| pix_de_i | input | 1 | Active-video data enable |
| pix_r_i | input | 8 | Red channel in |
| pix_g_i | input | 8 | Green channel in |
| pix_b_i | input | 8 | Blue channel in |
| hsync_i | input | 1 | Horizontal sync in |
| vsync_i | input | 1 | Vertical sync in |
| even_r_o | output | 8 | Even-bus red |
| even_g_o | output | 8 | Even-bus green |
| even_b_o | output | 8 | Even-bus blue |
| odd_r_o | output | 8 | Odd-bus red |
| odd_g_o | output | 8 | Odd-bus green |
| odd_b_o | output | 8 | Odd-bus blue |
| test_o | output | 4 | Spare pins: low in 8-bit mode, odd blue copy in 6-bit mode |
| de_o | output | 1 | Registered data enable |
| hsync_o | output | 1 | Registered horizontal sync |
| vsync_o | output | 1 | Registered vertical sync |
| dclk_full_o | output | 1 | Full-rate data clock |
| dclk_full_n_o | output | 1 | Inverted full-rate data clock |
| dclk_half_o | output | 1 | Half-rate data clock |
| dclk_half_n_o | output | 1 | Inverted half-rate data clock |

## Verification
The fault to fear most is a wrong pairing phase. It shows at the ports at the first pair after a data-enable rise, as swapped or shifted pixels between the even and odd buses. If a stalled valid cycle advances the phase, the pair that follows is misaligned within two clocks. A stale hold register shows as the previous line's pixel on the even bus, and the half-rate clock then fails to be high right after the pair update. A wrong depth multiplexer is visible at once at every channel output and at test_o, with no pipeline in between.

// File: rtl/panel_out_pkg.sv
package panel_out_pkg;
  localparam int CHAN_W   = 8;
  localparam int NARROW_W = 6;
  localparam int TEST_W   = 4;
  localparam int NCHAN    = 3;

  typedef struct packed {
    logic [CHAN_W-1:0] r;
    logic [CHAN_W-1:0] g;
    logic [CHAN_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/panel_pair_ctrl.sv
module panel_pair_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dual_phase_i,
  input  logic valid_i,
  input  logic de_i,
  output logic hold_ld_o,
  output logic pair_ld_o,
  output logic single_ld_o,
  output logic half_clk_o
);
  logic acc, ph_q, half_q;

  assign acc         = valid_i & de_i;
  assign hold_ld_o   = acc & dual_phase_i & ~ph_q;
  assign pair_ld_o   = acc & dual_phase_i & ph_q;
  assign single_ld_o = acc & ~dual_phase_i;
  assign half_clk_o  = half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 1'b0;
      half_q <= 1'b0;
    end else if (dual_phase_i && de_i) begin
      if (acc) begin
        ph_q   <= ~ph_q;
        half_q <= ph_q;   // high after pair completes
      end
    end else begin
      ph_q   <= 1'b0;     // next active pixel starts a pair
      half_q <= ~half_q;
    end
  end

  // R9
  pair_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_ld_o |=> half_q);
  // R9
  first_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_ld_o |=> !half_q);
  // R11
  stall_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_phase_i && de_i && !valid_i) |=> $stable(ph_q));
endmodule

// File: rtl/panel_pix_regs.sv
module panel_pix_regs
  import panel_out_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  rgb_t pix_i,
  input  logic hold_ld_i,
  input  logic pair_ld_i,
  input  logic single_ld_i,
  input  logic de_i,
  input  logic hsync_i,
  input  logic vsync_i,
  output rgb_t even_o,
  output rgb_t odd_o,
  output logic de_o,
  output logic hsync_o,
  output logic vsync_o
);
  rgb_t hold_q, even_q, odd_q;
  logic de_q, hs_q, vs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      even_q <= '0;
      odd_q  <= '0;
      de_q   <= 1'b0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
    end else begin
      if (hold_ld_i) hold_q <= pix_i;
      if (pair_ld_i) even_q <= hold_q;
      if (pair_ld_i || single_ld_i) odd_q <= pix_i;
      de_q <= de_i;
      hs_q <= hsync_i;
      vs_q <= vsync_i;
    end
  end

  assign even_o  = even_q;
  assign odd_o   = odd_q;
  assign de_o    = de_q;
  assign hsync_o = hs_q;
  assign vsync_o = vs_q;

  // R3
  even_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pair_ld_i |=> $stable(even_q));
  // R4
  single_odd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_ld_i |=> (odd_q == $past(pix_i)));
  // R11
  odd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pair_ld_i || single_ld_i) |=> $stable(odd_q));
endmodule

// File: rtl/panel_depth_fmt.sv
module panel_depth_fmt
  import panel_out_pkg::*;
(
  input  logic                           wide_i,
  input  logic [2*NCHAN-1:0][CHAN_W-1:0] chan_i,
  output logic [2*NCHAN-1:0][CHAN_W-1:0] chan_o,
  output logic [TEST_W-1:0]              test_o
);
  localparam int PAD_W = CHAN_W - NARROW_W;
  localparam int ODD_B = 0;

  for (genvar i = 0; i < 2*NCHAN; i++) begin : g_chan
    assign chan_o[i] = wide_i ? chan_i[i]
                              : {{PAD_W{1'b0}}, chan_i[i][CHAN_W-1 -: NARROW_W]};
  end

  assign test_o = wide_i ? '0 : chan_o[ODD_B][NARROW_W-1 -: TEST_W];

  // R6
  narrow_pad_chk: assert final (wide_i || chan_o[1][CHAN_W-1 -: PAD_W] == '0);
  // R7
  test_low_chk: assert final (!wide_i || test_o == '0);
endmodule

// File: rtl/panel_out_fmt.sv
module panel_out_fmt
  import panel_out_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dual_phase_i,
  input  logic              wide_i,
  input  logic              pix_valid_i,
  input  logic              pix_de_i,
  input  logic [CHAN_W-1:0] pix_r_i,
  input  logic [CHAN_W-1:0] pix_g_i,
  input  logic [CHAN_W-1:0] pix_b_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  output logic [CHAN_W-1:0] even_r_o,
  output logic [CHAN_W-1:0] even_g_o,
  output logic [CHAN_W-1:0] even_b_o,
  output logic [CHAN_W-1:0] odd_r_o,
  output logic [CHAN_W-1:0] odd_g_o,
  output logic [CHAN_W-1:0] odd_b_o,
  output logic [TEST_W-1:0] test_o,
  output logic              de_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              dclk_full_o,
  output logic              dclk_full_n_o,
  output logic              dclk_half_o,
  output logic              dclk_half_n_o
);
  logic hold_ld, pair_ld, single_ld, half_clk;
  rgb_t pix, even_q, odd_q;
  logic [2*NCHAN-1:0][CHAN_W-1:0] raw, fmt;

  assign pix = '{r: pix_r_i, g: pix_g_i, b: pix_b_i};

  panel_pair_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dual_phase_i (dual_phase_i),
    .valid_i      (pix_valid_i),
    .de_i         (pix_de_i),
    .hold_ld_o    (hold_ld),
    .pair_ld_o    (pair_ld),
    .single_ld_o  (single_ld),
    .half_clk_o   (half_clk)
  );

  panel_pix_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pix_i       (pix),
    .hold_ld_i   (hold_ld),
    .pair_ld_i   (pair_ld),
    .single_ld_i (single_ld),
    .de_i        (pix_de_i),
    .hsync_i     (hsync_i),
    .vsync_i     (vsync_i),
    .even_o      (even_q),
    .odd_o       (odd_q),
    .de_o        (de_o),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o)
  );

  // index 0 is odd blue (feeds the spare pins)
  assign raw = {even_q.r, even_q.g, even_q.b, odd_q.r, odd_q.g, odd_q.b};

  panel_depth_fmt u_fmt (
    .wide_i (wide_i),
    .chan_i (raw),
    .chan_o (fmt),
    .test_o (test_o)
  );

  assign {even_r_o, even_g_o, even_b_o, odd_r_o, odd_g_o, odd_b_o} = fmt;

  assign dclk_full_o   = clk_i;
  assign dclk_full_n_o = ~clk_i;
  assign dclk_half_o   = half_clk;
  assign dclk_half_n_o = ~half_clk;

  // R10
  de_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (de_o == $past(pix_de_i)));
  // R9
  idle_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pix_de_i || !dual_phase_i) |=> (dclk_half_o != $past(dclk_half_o)));
  // R5
  wide_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_i && single_ld) |=> (!wide_i || odd_r_o == $past(pix_r_i)));
endmodule

// File: tb/panel_out_fmt_tb.sv
module panel_out_fmt_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic dual = 1'b1, wide = 1'b1, valid = 1'b0, de = 1'b0, hs = 1'b0, vs = 1'b0;
  logic [7:0] r = '0, g = '0, b = '0;
  logic [7:0] er, eg, eb, orr, og, ob;
  logic [3:0] tst;
  logic de_o, hs_o, vs_o, fclk, fclk_n, hclk, hclk_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  panel_out_fmt dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .dual_phase_i(dual), .wide_i(wide),
    .pix_valid_i(valid), .pix_de_i(de), .pix_r_i(r), .pix_g_i(g), .pix_b_i(b),
    .hsync_i(hs), .vsync_i(vs),
    .even_r_o(er), .even_g_o(eg), .even_b_o(eb),
    .odd_r_o(orr), .odd_g_o(og), .odd_b_o(ob), .test_o(tst),
    .de_o(de_o), .hsync_o(hs_o), .vsync_o(vs_o),
    .dclk_full_o(fclk), .dclk_full_n_o(fclk_n),
    .dclk_half_o(hclk), .dclk_half_n_o(hclk_n));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, return at next negedge
  task automatic cyc(logic v, logic e, logic [23:0] px);
    valid = v; de = e; {r, g, b} = px;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 buses", {er, eg, eb, orr}, 32'h0);
    check("R1 ctl", {og, ob, tst, de_o, hs_o, vs_o, hclk}, 32'h0);
    rst_ni = 1'b1;
  endtask

  task automatic t_dual();
    dual = 1; wide = 1;
    cyc(0, 0, 24'h0);
    cyc(1, 1, 24'h112233);
    check("R3 first held", {er, eg, eb, orr, og, ob}, 32'h0);
    check("R9 half low after first", hclk, 0);
    cyc(1, 1, 24'h445566);
    check("R2 even", {er, eg, eb}, 32'h112233);
    check("R2 odd", {orr, og, ob}, 32'h445566);
    check("R9 half high after pair", {hclk, hclk_n}, 2'b10);
    check("R10 de", de_o, 1);
    cyc(1, 1, 24'h778899);
    check("R3 hold even", {er, eg, eb}, 32'h112233);
    check("R3 hold odd", {orr, og, ob}, 32'h445566);
    cyc(0, 1, 24'hFFFFFF);
    check("R11 stall", {orr, og, ob}, 32'h445566);
    cyc(1, 1, 24'hAABBCC);
    check("R11 stall no advance even", {er, eg, eb}, 32'h778899);
    check("R11 stall no advance odd", {orr, og, ob}, 32'hAABBCC);
    cyc(0, 0, 24'h0);
    check("R10 de low", de_o, 0);
    cyc(1, 1, 24'h010203);
    cyc(0, 0, 24'h0);
    cyc(1, 1, 24'h0A0B0C);
    cyc(1, 1, 24'h0D0E0F);
    check("R2 restart even", {er, eg, eb}, 32'h0A0B0C);
    check("R2 restart odd", {orr, og, ob}, 32'h0D0E0F);
  endtask

  task automatic t_single();
    dual = 0;
    cyc(1, 1, 24'hC3A55A);
    check("R4 odd", {orr, og, ob}, 32'hC3A55A);
    check("R4 even kept", {er, eg, eb}, 32'h0A0B0C);
    cyc(1, 1, 24'h3C5AA5);
    check("R4 odd next", {orr, og, ob}, 32'h3C5AA5);
    cyc(1, 0, 24'h999999);
    check("R11 de low", {orr, og, ob}, 32'h3C5AA5);
  endtask

  task automatic t_depth();
    wide = 0; #1;
    check("R6 odd r", orr, {2'b00, 6'h0F});
    check("R6 even r", er, {2'b00, 6'h02});
    check("R7 test 6bit", tst, 4'hA);
    wide = 1; #1;
    check("R7 test 8bit", tst, 4'h0);
    check("R5 odd b", ob, 8'hA5);
  endtask

  task automatic t_clocks();
    logic h0;
    @(posedge clk); #2;
    check("R8 high", {fclk, fclk_n}, 2'b10);
    @(negedge clk); #1;
    check("R8 low", {fclk, fclk_n}, 2'b01);
    valid = 0; de = 0;
    @(negedge clk); h0 = hclk;
    @(negedge clk);
    check("R9 toggle", {hclk, hclk_n}, {~h0, h0});
  endtask

  task automatic t_sync();
    hs = 1; vs = 0;
    @(negedge clk);
    check("R10 hs", {hs_o, vs_o}, 2'b10);
    hs = 0; vs = 1;
    @(negedge clk);
    check("R10 vs", {hs_o, vs_o}, 2'b01);
    vs = 0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_dual();
    t_single();
    t_depth();
    t_clocks();
    t_sync();
    report();
  end
endmodule